// File: doc/BRIEF.md
# Processor Status and Control Register

This block is the processor's status and control byte, placed in the register file at a fixed address that every bank selection reaches. It holds one bit software can write, the global interrupt disable, and three flags that only hardware maintains. The first flag marks that the hardware return stack still has room. The second records a watchdog expiry. The third records entry into sleep. The block also produces a registered global interrupt mask for the interrupt logic.

The stack flag comes from a 4-bit stack pointer kept inside the block. Push and pop strobes step the pointer. When a push carries the pointer from its top value back to zero, the flag drops. Once down, it stays down until a device reset, even if the stack is later popped. A processor write to the register changes only the interrupt disable bit. Writing the full byte can therefore leave a value other than the one written.

Top module: `cpu_status_reg`

## Requirements
- R1: Synchronous active-high reset gives `rd_data` = 8'h3C (stack flag, disable, time-out and power-down flags all 1), `irq_block` = 1, and a stack pointer of 0.
- R2: Bits 7, 6, 1 and 0 of `rd_data` always read 0, whatever has been written.
- R3: Bit 5 (stack available) clears on the push that carries the pointer from 15 to 0. Pops never set it again. Only reset sets it.
- R4: A lone push adds 1 to the pointer modulo 16, and a lone pop subtracts 1 modulo 16. A push and a pop in the same cycle leave the pointer unchanged. Only the increment from 15 to 0 affects bit 5.
- R5: A write with `wr_addr` = 8'h06 loads `wr_data[4]` into bit 4. A write to any other address leaves bit 4 unchanged.
- R6: A processor write never changes bits 5, 3 or 2.
- R7: Bit 3 (time-out) clears on `wdt_expire` and sets on `wdt_clr`. If both arrive in one cycle, `wdt_expire` takes effect.
- R8: Bit 2 (power-down) clears on `sleep_cmd` and sets on `wdt_clr`. If both arrive in one cycle, `sleep_cmd` takes effect.
- R9: `irq_block` equals bit 4 and is registered. It changes at the clock edge that captures the write.
- R10: When a hardware event and a register write arrive in the same cycle, both take effect: the event on its flag, and the write on bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register-file write enable |
| wr_addr | input | 8 | Register-file write address |
| wr_data | input | 8 | Register-file write data |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| wdt_clr | input | 1 | Watchdog-clear instruction strobe |
| sleep_cmd | input | 1 | Sleep instruction strobe |
| wdt_expire | input | 1 | Watchdog time-out strobe |
| rd_data | output | 8 | Current register value |
| irq_block | output | 1 | Global interrupt mask (1 blocks all interrupts) |

## Verification
The assertions assume that every strobe is a single-cycle pulse sampled on the rising edge. They also assume that outputs seen in the cycle a strobe is present still show the old state. The write-isolation property assumes that no hardware event shares the cycle with the write. The bench meets these assumptions by changing inputs only on falling edges and clearing every strobe after one cycle. It keeps the combined event-and-write cases in dedicated steps, and the checks there follow R10.

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 6,
  parameter int SP_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              push,
  input  logic              pop,
  input  logic              wdt_clr,
  input  logic              sleep_cmd,
  input  logic              wdt_expire,
  output logic [7:0]        rd_data,
  output logic              irq_block
);
  localparam logic [SP_W-1:0]   SP_TOP = '1;
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(REG_ADDR);

  logic [SP_W-1:0] sp;
  logic stk_av, gid, to_f, pd_f;

  wire sel  = wr_en && (wr_addr == SEL_A);
  wire up   = push && !pop;
  wire down = pop && !push;
  wire wrap = up && (sp == SP_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp     <= '0;
      stk_av <= 1'b1;
      gid    <= 1'b1;
      to_f   <= 1'b1;
      pd_f   <= 1'b1;
    end else begin
      if (up)        sp <= sp + 1'b1;
      else if (down) sp <= sp - 1'b1;
      if (wrap) stk_av <= 1'b0;
      if (sel)  gid <= wr_data[4];
      if (wdt_expire)   to_f <= 1'b0;
      else if (wdt_clr) to_f <= 1'b1;
      if (sleep_cmd)    pd_f <= 1'b0;
      else if (wdt_clr) pd_f <= 1'b1;
    end
  end

  assign rd_data   = {2'b00, stk_av, gid, to_f, pd_f, 2'b00};
  assign irq_block = gid;

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:6] == 2'b00 && rd_data[1:0] == 2'b00);

  p_stack_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_data[5] |=> !rd_data[5]);

  p_other_addr_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == SEL_A) |=> $stable(irq_block));

  p_write_isolated_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !push && !wdt_clr && !wdt_expire && !sleep_cmd)
    |=> $stable(rd_data[5]) && $stable(rd_data[3:2]));

  p_expire_wins_r7: assert property (@(posedge clk) disable iff (rst)
    wdt_expire |=> !rd_data[3]);

  p_sleep_wins_r8: assert property (@(posedge clk) disable iff (rst)
    sleep_cmd |=> !rd_data[2]);

  p_mask_follows_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SEL_A) |=> irq_block == $past(wr_data[4]));
endmodule

// File: tb/cpu_status_reg_test.sv
module cpu_status_reg_test;
  logic clk = 1'b0;
  logic rst, wr_en, push, pop, wdt_clr, sleep_cmd, wdt_expire;
  logic [7:0] wr_addr, wr_data, rd_data;
  logic irq_block;

  int checks = 0, fails = 0;
  logic m_stk, m_gid, m_to, m_pd;

  always #2 clk = ~clk;

  cpu_status_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .push(push), .pop(pop), .wdt_clr(wdt_clr), .sleep_cmd(sleep_cmd),
    .wdt_expire(wdt_expire), .rd_data(rd_data), .irq_block(irq_block));

  function automatic logic [7:0] exp_val();
    return {2'b00, m_stk, m_gid, m_to, m_pd, 2'b00};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_addr = 0; wr_data = 0; push = 0; pop = 0;
    wdt_clr = 0; sleep_cmd = 0; wdt_expire = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle(); rst = 1; tick(); rst = 0;
    m_stk = 1; m_gid = 1; m_to = 1; m_pd = 1;
  endtask

  task automatic pushes(input int n);
    for (int i = 0; i < n; i++) begin push = 1; tick(); end
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1; idle();
    @(negedge clk);
    do_reset();
    check("R1 reset value", rd_data, 8'h3C);
    check("R1 reset mask", {7'd0, irq_block}, 8'h01);

    // R5 R6 R2 R9: every data value to the register
    for (int d = 0; d < 256; d++) begin
      wr_en = 1; wr_addr = 8'h06; wr_data = 8'(d); tick();
      m_gid = d[4];
      check("R5 R6 R2 write", rd_data, exp_val());
      check("R9 mask", {7'd0, irq_block}, {7'd0, m_gid});
    end
    // R5: other addresses ignored
    for (int a = 0; a < 256; a++) begin
      if (a == 6) continue;
      wr_en = 1; wr_addr = 8'(a); wr_data = {3'b000, ~m_gid, 4'h0}; tick();
      check("R5 other address", rd_data, exp_val());
    end

    // R3 R4: n pushes from reset
    for (int n = 0; n <= 20; n++) begin
      do_reset();
      pushes(n);
      m_stk = (n < 16);
      check("R3 push count", rd_data, exp_val());
    end
    // R3: pops never restore
    pushes(3);
    for (int i = 0; i < 18; i++) begin pop = 1; tick(); end
    check("R3 sticky after pops", rd_data, exp_val());
    // R4: pop from 0 wraps to 15, next push clears
    do_reset();
    pop = 1; tick();
    check("R4 pop wrap keeps flag", rd_data, exp_val());
    pushes(1); m_stk = 0;
    check("R4 push after pop wrap", rd_data, exp_val());
    // R4: simultaneous push and pop leave pointer at 15
    do_reset();
    pushes(15);
    for (int i = 0; i < 5; i++) begin push = 1; pop = 1; tick(); end
    check("R4 push+pop hold", rd_data, exp_val());
    pushes(1); m_stk = 0;
    check("R4 wrap after hold", rd_data, exp_val());

    // R7 R8: all strobe combinations from each flag state
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 8; c++) begin
        wdt_clr = c[0]; wdt_expire = c[1]; sleep_cmd = c[2]; tick();
        if (c[1]) m_to = 0; else if (c[0]) m_to = 1;
        if (c[2]) m_pd = 0; else if (c[0]) m_pd = 1;
        check("R7 R8 watchdog flags", rd_data, exp_val());
      end

    // R10: events with writes in the same cycle
    do_reset();
    pushes(15);
    push = 1; wdt_expire = 1; sleep_cmd = 1;
    wr_en = 1; wr_addr = 8'h06; wr_data = 8'hFF & ~8'h10; tick();
    m_stk = 0; m_to = 0; m_pd = 0; m_gid = 0;
    check("R10 events with write", rd_data, exp_val());
    check("R10 R9 mask", {7'd0, irq_block}, 8'h00);
    wdt_clr = 1; wr_en = 1; wr_addr = 8'h06; wr_data = 8'h10; tick();
    m_to = 1; m_pd = 1; m_gid = 1;
    check("R10 clear with write", rd_data, exp_val());
    wr_en = 1; wr_addr = 8'h06; wr_data = 8'hFF; tick();
    check("R6 R2 full write", rd_data, 8'h1C);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule